// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Parallel Test Mode

This block sits on the device side of an asynchronous DRAM interface. It samples the active-low row strobe, column strobe and write enable on a system clock. From the order in which the strobes change, it sorts every row-strobe cycle into one of four kinds: an ordinary access, a refresh that uses an external row with the column strobe held inactive, a refresh where the column strobe leads the row strobe, and a hidden refresh that follows a read while the column strobe stays asserted. It reports which kind each cycle is, together with the row that the cycle touched. Refreshes that are addressed internally take their row from a wrapping refresh counter.

A parallel test mode makes the array look four times narrower on each data line. The mode is entered and left only through particular refresh variants. While it is active, the two lowest column address bits are forced to zero. Each data line also reports whether the four internal bits behind it all hold the same value. The storage array and analog timing checks lie outside this block. The array supplies the internal bits, and it uses the reported row, column and drive indication.

All strobe inputs pass through one sampling register before the edges are detected. The state machine has five states:
- ST_IDLE: row strobe inactive.
- ST_ROW_OPEN: row strobe active, column strobe not yet asserted.
- ST_ACCESS: column strobe asserted inside an open row.
- ST_CBR: column-first refresh.
- ST_HIDDEN: hidden refresh.

The transitions are:
- ST_IDLE to ST_ROW_OPEN when the row strobe falls with the column strobe high.
- ST_IDLE to ST_CBR when the row strobe falls with the column strobe low and no read is being held.
- ST_IDLE to ST_HIDDEN when the row strobe falls with the column strobe low and a read is being held.
- ST_ROW_OPEN to ST_ACCESS when the column strobe falls.
- ST_ROW_OPEN to ST_IDLE when the row strobe rises (external-row refresh).
- ST_ACCESS, ST_CBR and ST_HIDDEN to ST_IDLE when the row strobe rises.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, the outputs are: cycle type NONE (0), row 0, column 0, test flag 0, drive 0, agreement bits 0, and no valid pulse. The refresh counter is 0.
- R2: The column strobe is low when the row strobe falls, and no read is being held. This is reported as CBR (3) in the cycle that follows the fall. The reported row is the current refresh counter value, and the counter then advances by one.
- R3: The row strobe falls and then rises while the column strobe stays high. This is reported as ROW_ONLY (2) when the row strobe rises. The reported row is the address sampled at the fall, and drive stays 0.
- R4: The column strobe falls inside an open row. This is reported as ACCESS (1) with the row latched at the row fall and the address sampled at the column fall as the column. Drive goes to 1 only if write enable is high at that column fall.
- R5: The row strobe falls again while the column strobe is still held low after an ACCESS read. This is reported as HIDDEN (4) with the refresh counter as the row, and the counter advances. Drive stays 1 until the column strobe rises.
- R6: While the column strobe is held low, every row strobe fall is a new CBR refresh and advances the counter by one.
- R7: A CBR refresh with write enable low sets the test flag, and the counter still advances for that cycle.
- R8: A CBR refresh with write enable high, or a ROW_ONLY refresh, clears the test flag. A hidden refresh leaves the test flag as it is.
- R9: While the test flag is 1, the two lowest bits of the reported column are 0.
- R10: Agreement bit i is 1 when internal bits [4i+3:4i] are all 0 or all 1, and 0 otherwise. It is updated one clock after the bits, and only while the test flag is 1. Otherwise it is 0.
- R11: The refresh counter is 12 bits wide. After it reports row 4095, the next internal refresh reports row 0.
- R12: Each classified cycle raises the valid output for exactly one clock. A hidden refresh after a read gives two pulses: one for the read and one for the refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| arr_bits | input | 16 | Internal bits, four per data line, line i at [4i+3:4i] |
| cyc_valid | output | 1 | One-clock pulse when a cycle is classified |
| cyc_type | output | 3 | Kind of the last classified cycle (NONE 0, ACCESS 1, ROW_ONLY 2, CBR 3, HIDDEN 4) |
| row_out | output | 12 | Row used by the last classified cycle |
| col_out | output | 12 | Column of the last access, low two bits masked in test mode |
| test_mode | output | 1 | Parallel test mode active |
| dq_drive | output | 1 | Read data is being driven or held |
| dq_agree | output | 4 | Per-line four-bit agreement in test mode |

## Verification
A table of strobe sequences takes the decoder through each cycle kind, in an order that interleaves external-row refreshes, column-first refreshes with write enable both high and low, early writes, reads, and a read followed by a hidden refresh. This separates classification by strobe order from classification by the write-enable level, and it shows which kinds of cycle move the counter. A long run of row pulses with the column strobe held low tells back-to-back column-first refreshes apart from a single refresh, and it drives the counter across its wrap. Agreement patterns made of all ones, all zeros, alternating bits and a single set bit, presented inside and outside test mode, show that the compare is gated and that it counts all-zero groups as agreeing.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

    typedef enum logic [2:0] {
        CYC_NONE     = 3'd0,
        CYC_ACCESS   = 3'd1,
        CYC_ROW_ONLY = 3'd2,
        CYC_CBR      = 3'd3,
        CYC_HIDDEN   = 3'd4
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ROW_OPEN = 3'd1,
        ST_ACCESS   = 3'd2,
        ST_CBR      = 3'd3,
        ST_HIDDEN   = 3'd4
    } fsm_state_e;

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output logic          ras_fall,
    output logic          ras_rise,
    output logic          cas_fall,
    output logic          cas_rise,
    output logic          cas_low,
    output logic          we_low,
    output logic [AW-1:0] addr_s
);

    logic s_ras, p_ras, s_cas, p_cas, s_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ras  <= 1'b1;
            p_ras  <= 1'b1;
            s_cas  <= 1'b1;
            p_cas  <= 1'b1;
            s_we   <= 1'b1;
            addr_s <= '0;
        end else begin
            s_ras  <= ras_n;
            p_ras  <= s_ras;
            s_cas  <= cas_n;
            p_cas  <= s_cas;
            s_we   <= we_n;
            addr_s <= addr;
        end
    end

    assign ras_fall = p_ras & ~s_ras;
    assign ras_rise = ~p_ras & s_ras;
    assign cas_fall = p_cas & ~s_cas;
    assign cas_rise = ~p_cas & s_cas;
    assign cas_low  = ~s_cas;
    assign we_low   = ~s_we;

endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] row
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (inc) begin
            row <= row + 1'b1;
        end
    end

endmodule

// File: rtl/agree_cmp.sv
module agree_cmp #(
    parameter int DQ  = 4,
    parameter int GRP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DQ*GRP-1:0] bits,
    output logic [DQ-1:0]     agree
);

    logic [DQ-1:0] agree_c;

    for (genvar i = 0; i < DQ; i++) begin : g_line
        logic [GRP-1:0] grp;
        assign grp        = bits[i*GRP +: GRP];
        assign agree_c[i] = (&grp) | ~(|grp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            agree <= '0;
        end else begin
            agree <= en ? agree_c : '0;
        end
    end

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import sdec_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ras_fall,
    input  logic         ras_rise,
    input  logic         cas_fall,
    input  logic         cas_rise,
    input  logic         cas_low,
    input  logic         we_low,
    input  logic [W-1:0] addr_s,
    input  logic [W-1:0] ref_row,
    output logic         ref_inc,
    output logic         cyc_valid,
    output cyc_kind_e    cyc_type,
    output logic [W-1:0] row_out,
    output logic [W-1:0] col_out,
    output logic         test_mode,
    output logic         hold_read
);

    localparam int MASK_BITS = 2;

    fsm_state_e    state, state_nx;
    logic [W-1:0]  row_lat;
    logic [W-1:0]  col_masked;

    assign col_masked = {addr_s[W-1:MASK_BITS], {MASK_BITS{1'b0}}};
    assign ref_inc    = (state == ST_IDLE) && ras_fall && cas_low;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (!cas_low)       state_nx = ST_ROW_OPEN;
                    else if (hold_read) state_nx = ST_HIDDEN;
                    else                state_nx = ST_CBR;
                end
            end
            ST_ROW_OPEN: begin
                if (ras_rise)      state_nx = ST_IDLE;
                else if (cas_fall) state_nx = ST_ACCESS;
            end
            ST_ACCESS, ST_CBR, ST_HIDDEN: begin
                if (ras_rise) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_valid <= 1'b0;
            cyc_type  <= CYC_NONE;
            row_out   <= '0;
            col_out   <= '0;
            row_lat   <= '0;
            test_mode <= 1'b0;
            hold_read <= 1'b0;
        end else begin
            cyc_valid <= 1'b0;
            if (cas_rise) hold_read <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ras_fall) begin
                        if (cas_low) begin
                            cyc_valid <= 1'b1;
                            row_out   <= ref_row;
                            if (hold_read) begin
                                cyc_type <= CYC_HIDDEN;
                            end else begin
                                cyc_type  <= CYC_CBR;
                                test_mode <= we_low;
                            end
                        end else begin
                            row_lat <= addr_s;
                        end
                    end
                end
                ST_ROW_OPEN: begin
                    if (ras_rise) begin
                        cyc_valid <= 1'b1;
                        cyc_type  <= CYC_ROW_ONLY;
                        row_out   <= row_lat;
                        test_mode <= 1'b0;
                    end else if (cas_fall) begin
                        cyc_valid <= 1'b1;
                        cyc_type  <= CYC_ACCESS;
                        row_out   <= row_lat;
                        col_out   <= test_mode ? col_masked : addr_s;
                        hold_read <= ~we_low;
                    end
                end
                ST_ACCESS, ST_CBR, ST_HIDDEN: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import sdec_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int DQ_W  = 4,
    parameter int GRP   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [ROW_W-1:0]      addr,
    input  logic [DQ_W*GRP-1:0]   arr_bits,
    output logic                  cyc_valid,
    output logic [2:0]            cyc_type,
    output logic [ROW_W-1:0]      row_out,
    output logic [ROW_W-1:0]      col_out,
    output logic                  test_mode,
    output logic                  dq_drive,
    output logic [DQ_W-1:0]       dq_agree
);

    logic             ras_fall, ras_rise, cas_fall, cas_rise, cas_low, we_low;
    logic [ROW_W-1:0] addr_s;
    logic [ROW_W-1:0] ref_row;
    logic             ref_inc;
    cyc_kind_e        kind;

    strobe_sampler #(.AW(ROW_W)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .addr     (addr),
        .ras_fall (ras_fall),
        .ras_rise (ras_rise),
        .cas_fall (cas_fall),
        .cas_rise (cas_rise),
        .cas_low  (cas_low),
        .we_low   (we_low),
        .addr_s   (addr_s)
    );

    refresh_ctr #(.W(ROW_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .row   (ref_row)
    );

    cycle_fsm #(.W(ROW_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_fall  (ras_fall),
        .ras_rise  (ras_rise),
        .cas_fall  (cas_fall),
        .cas_rise  (cas_rise),
        .cas_low   (cas_low),
        .we_low    (we_low),
        .addr_s    (addr_s),
        .ref_row   (ref_row),
        .ref_inc   (ref_inc),
        .cyc_valid (cyc_valid),
        .cyc_type  (kind),
        .row_out   (row_out),
        .col_out   (col_out),
        .test_mode (test_mode),
        .hold_read (dq_drive)
    );

    agree_cmp #(.DQ(DQ_W), .GRP(GRP)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (test_mode),
        .bits  (arr_bits),
        .agree (dq_agree)
    );

    assign cyc_type = kind;

endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk #(
    parameter int ROW_W = 12,
    parameter int DQ_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_valid,
    input logic [2:0]       cyc_type,
    input logic [ROW_W-1:0] col_out,
    input logic [ROW_W-1:0] ref_row,
    input logic             test_mode,
    input logic             dq_drive,
    input logic [DQ_W-1:0]  dq_agree
);

    logic is_ref;
    assign is_ref = cyc_valid && (cyc_type == 3'd3 || cyc_type == 3'd4);

    // R2: the counter moves only in a cycle reported as an internal refresh
    a_r2_cnt_only_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_row != $past(ref_row)) |-> is_ref);

    // R11: every internal refresh steps the counter by exactly one, modulo its width
    a_r11_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

    a_r3_row_only_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 3'd2) |-> !dq_drive);

    a_r7_entry_by_cbr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> (cyc_valid && cyc_type == 3'd3));

    a_r8_exit_by_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> (cyc_valid && (cyc_type == 3'd3 || cyc_type == 3'd2)));

    a_r9_col_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && cyc_valid && cyc_type == 3'd1) |-> (col_out[1:0] == 2'b00));

    a_r10_agree_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(test_mode) |-> (dq_agree == '0));

endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.ROW_W(ROW_W), .DQ_W(DQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .cyc_type  (cyc_type),
    .col_out   (col_out),
    .ref_row   (ref_row),
    .test_mode (test_mode),
    .dq_drive  (dq_drive),
    .dq_agree  (dq_agree)
);

// File: tb/dram_strobe_decoder_bench.sv
module dram_strobe_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] arr_bits = '0;
    logic        cyc_valid;
    logic [2:0]  cyc_type;
    logic [11:0] row_out;
    logic [11:0] col_out;
    logic        test_mode;
    logic        dq_drive;
    logic [3:0]  dq_agree;

    dram_strobe_decoder u_dram_strobe_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .arr_bits  (arr_bits),
        .cyc_valid (cyc_valid),
        .cyc_type  (cyc_type),
        .row_out   (row_out),
        .col_out   (col_out),
        .test_mode (test_mode),
        .dq_drive  (dq_drive),
        .dq_agree  (dq_agree)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always @(posedge clk) if (rst_n && cyc_valid) pulses++;

    // kinds: 0 read, 1 early write, 2 external-row refresh, 3 CBR we high, 4 CBR we low, 5 read + hidden
    typedef struct packed {
        logic [2:0]  kind;
        logic [11:0] row;
        logic [11:0] col;
        logic [2:0]  etype;
        logic [11:0] erow;
        logic        etest;
        logic [11:0] ecol;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{3'd2, 12'h123, 12'h000, 3'd2, 12'h123, 1'b0, 12'h000},
        '{3'd3, 12'h000, 12'h000, 3'd3, 12'h000, 1'b0, 12'h000},
        '{3'd1, 12'h2AB, 12'h0F7, 3'd1, 12'h2AB, 1'b0, 12'h0F7},
        '{3'd5, 12'h055, 12'h011, 3'd4, 12'h001, 1'b0, 12'h011},
        '{3'd4, 12'h000, 12'h000, 3'd3, 12'h002, 1'b1, 12'h000},
        '{3'd0, 12'hABC, 12'h3FF, 3'd1, 12'hABC, 1'b1, 12'h3FC},
        '{3'd3, 12'h000, 12'h000, 3'd3, 12'h003, 1'b0, 12'h000},
        '{3'd4, 12'h000, 12'h000, 3'd3, 12'h004, 1'b1, 12'h000},
        '{3'd2, 12'h777, 12'h000, 3'd2, 12'h777, 1'b0, 12'h000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_access(input logic [11:0] row, input logic [11:0] col,
                             input bit wr, input bit keep_cas);
        addr = row; wn(1);
        ras_n = 1'b0; wn(3);
        addr = col; we_n = wr ? 1'b0 : 1'b1; cas_n = 1'b0; wn(3);
        ras_n = 1'b1; wn(3);
        we_n = 1'b1;
        if (!keep_cas) begin cas_n = 1'b1; wn(3); end
    endtask

    task automatic do_row_only(input logic [11:0] row);
        addr = row; wn(1);
        ras_n = 1'b0; wn(3);
        ras_n = 1'b1; wn(3);
    endtask

    task automatic do_cbr(input bit we_low);
        we_n = ~we_low; cas_n = 1'b0; wn(2);
        ras_n = 1'b0; wn(3);
        ras_n = 1'b1; wn(2);
        cas_n = 1'b1; we_n = 1'b1; wn(3);
    endtask

    task automatic do_hidden(input logic [11:0] row, input logic [11:0] col);
        do_access(row, col, 1'b0, 1'b1);
        chk("R5 read data held after row strobe rise", dq_drive, 1);
        ras_n = 1'b0; wn(3);
        chk("R5 read data held during hidden refresh", dq_drive, 1);
        ras_n = 1'b1; wn(2);
        cas_n = 1'b1; wn(3);
        chk("R5 drive released at column rise", dq_drive, 0);
    endtask

    initial begin
        int p0;
        wn(3);
        rst_n = 1'b1;
        wn(2);
        chk("R1 reset type", cyc_type, 0);
        chk("R1 reset row", row_out, 0);
        chk("R1 reset column", col_out, 0);
        chk("R1 reset test flag", test_mode, 0);
        chk("R1 reset drive", dq_drive, 0);
        chk("R1 reset agree", dq_agree, 0);
        chk("R1 reset valid", cyc_valid, 0);

        foreach (TBL[i]) begin
            p0 = pulses;
            case (TBL[i].kind)
                3'd0: do_access(TBL[i].row, TBL[i].col, 1'b0, 1'b0);
                3'd1: begin
                    addr = TBL[i].row; wn(1);
                    ras_n = 1'b0; wn(3);
                    addr = TBL[i].col; we_n = 1'b0; cas_n = 1'b0; wn(3);
                    chk("R4 early write leaves drive off", dq_drive, 0);
                    ras_n = 1'b1; wn(3);
                    we_n = 1'b1; cas_n = 1'b1; wn(3);
                end
                3'd2: do_row_only(TBL[i].row);
                3'd3: do_cbr(1'b0);
                3'd4: do_cbr(1'b1);
                default: do_hidden(TBL[i].row, TBL[i].col);
            endcase
            chk($sformatf("R2 R3 R4 R5 type entry %0d", i), cyc_type, TBL[i].etype);
            chk($sformatf("R2 R3 R4 R5 row entry %0d", i), row_out, TBL[i].erow);
            chk($sformatf("R7 R8 test flag entry %0d", i), test_mode, TBL[i].etest);
            chk($sformatf("R3 drive idle entry %0d", i), dq_drive, 0);
            if (TBL[i].etype == 3'd1)
                chk($sformatf("R4 R9 column entry %0d", i), col_out, TBL[i].ecol);
            chk($sformatf("R12 pulses entry %0d", i), pulses - p0,
                (TBL[i].kind == 3'd5) ? 2 : 1);
        end

        // R6 and R11: column strobe held low, row strobe toggled; counter starts at 5
        cas_n = 1'b0; wn(2);
        for (int k = 0; k < 4096; k++) begin
            ras_n = 1'b0; wn(2);
            if (k < 2)
                chk("R6 back-to-back refresh row", row_out, 12'(5 + k));
            if (k == 4090)
                chk("R11 counter reaches top row", row_out, 12'hFFF);
            if (k == 4091)
                chk("R11 counter wraps to row 0", row_out, 12'h000);
            ras_n = 1'b1; wn(2);
        end
        chk("R6 back-to-back type", cyc_type, 3);
        cas_n = 1'b1; wn(3);

        // R10: agreement compare inside test mode
        arr_bits = 16'hFFFF; wn(3);
        chk("R10 agree gated outside test mode", dq_agree, 4'b0000);
        do_cbr(1'b1);
        chk("R7 test entry flag", test_mode, 1);
        arr_bits = {4'h8, 4'h5, 4'h0, 4'hF}; wn(2);
        chk("R10 mixed groups", dq_agree, 4'b0011);
        arr_bits = 16'hFFFF; wn(2);
        chk("R10 all ones", dq_agree, 4'b1111);
        arr_bits = 16'h1248; wn(2);
        chk("R10 single set bits", dq_agree, 4'b0000);
        do_hidden(12'h020, 12'h005);
        chk("R8 hidden keeps test flag", test_mode, 1);
        do_row_only(12'h010);
        chk("R8 exit by external-row refresh", test_mode, 0);
        arr_bits = 16'h0000; wn(3);
        chk("R10 agree zero after exit", dq_agree, 4'b0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule